// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block produces a slow clock for an output pin by dividing a chosen source by a power of two. Four candidate sources arrive as clock-enable strobes inside one system clock domain; a 2-bit field picks one, and a gate bit must be set for its strobes to reach a 16-stage binary divide counter. A 4-bit tap field N picks one counter bit, so the divided clock runs at Fin/2^(N+1), from Fin/2 down to Fin/65536.

Setting the run bit (a 0-to-1 change) clears the counter and starts it. Clearing the run bit does not cut the output short: the counter keeps going until the selected bit is low, then stops and holds the output low. The pin carries either the divided clock or a plain GPIO data bit, chosen by a mode bit. All fields sit in one configuration register loaded through a single write strobe.

Top module: `pow2_clk_out`

## Requirements
- R1: After reset, every configuration field is 0, the counter is stopped and cleared, `div_clk_o` is 0 and `pin_o` follows `gpio_dout_i`.
- R2: While running with a strobe on every cycle, the divided clock has a period of 2^(N+1) cycles and a high time of 2^N cycles, N being the tap field.
- R3: A 0-to-1 change of the run bit clears the counter and starts it on the next cycle; the tap value is captured at that moment.
- R4: When the run bit is cleared, the counter keeps advancing until the tapped bit is 0, then stops; no high pulse on `div_clk_o` is shorter than 2^N source ticks.
- R5: While stopped, the counter and the output stay frozen low; a tap change written while stopped only takes effect at the next run rising edge.
- R6: The source field picks the strobe input of the same index: 0 selects bit 0, 1 bit 1, 2 bit 2, 3 bit 3 (the system bus clock strobe); one count is made per selected strobe.
- R7: With the gate bit at 0, the counter does not advance and the divided clock holds its level.
- R8: With the mode bit at 1, `pin_o` equals `div_clk_o`; with it at 0, `pin_o` equals `gpio_dout_i`.
- R9: A write with `cfg_we_i` high loads `cfg_wdata_i` at the next clock edge: bits [3:0] tap, bit 4 run, bits [6:5] source, bit 7 gate, bit 8 pin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 4 | Clock-enable strobes of the four sources |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 9 | Configuration write data |
| gpio_dout_i | input | 1 | GPIO data bit for the pin |
| div_clk_o | output | 1 | Divided clock |
| pin_o | output | 1 | Pin output |

## Verification
A wrong count or a wrong tap shows on `div_clk_o` at the next toggle of the selected bit, at most 2^N source ticks later, as a shifted edge or a wrong period. A missed clear on the run rising edge moves the first high edge, and a stop decided at the wrong moment shows as a short high pulse or an output that keeps toggling after the run bit falls. The bench compares both outputs against a behavioural model on every cycle, so the first divergent edge is reported in the cycle it occurs.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned TAP_W = $clog2(CNT_W);
  localparam int unsigned N_SRC = 4;
  localparam int unsigned SRC_W = $clog2(N_SRC);

  typedef struct packed {
    logic             pin_clk;
    logic             gate;
    logic [SRC_W-1:0] src;
    logic             run;
    logic [TAP_W-1:0] tap;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/pow2_src_sel.sv
module pow2_src_sel #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SRC_W-1:0] sel_i,
  input  logic             gate_i,
  output logic             tick_o
);
  always_comb tick_o = gate_i & tick_i[sel_i];
endmodule

// File: rtl/pow2_div_core.sv
module pow2_div_core #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned TAP_W = $clog2(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             div_o
);
  logic             en_q, run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAP_W-1:0] tap_q;
  logic             rise, tap_bit;

  always_comb begin
    rise    = en_i & ~en_q;
    tap_bit = cnt_q[tap_q];
    div_o   = run_q & tap_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
      tap_q <= '0;
    end else begin
      en_q <= en_i;
      if (rise) begin
        cnt_q <= '0;
        run_q <= 1'b1;
        tap_q <= tap_i;
      end else if (run_q) begin
        // disabled: stop only once the tapped bit is low
        if (!en_i && !tap_bit) run_q <= 1'b0;
        else if (tick_i)       cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CLEAR_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q) |=> (cnt_q == '0) && run_q); // R3
  AST_STOP_WHEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !cnt_q[tap_q]); // R4
  AST_FROZEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !(en_i && !en_q)) |=> $stable(cnt_q) && !div_o); // R5
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && en_q && tick_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(en_i && !en_q)) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/pow2_pin_mux.sv
module pow2_pin_mux (
  input  logic clk_mode_i,
  input  logic div_i,
  input  logic gpio_i,
  output logic pin_o
);
  always_comb pin_o = clk_mode_i ? div_i : gpio_i;
endmodule

// File: rtl/pow2_clk_out.sv
module pow2_clk_out
  import pow2_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             gpio_dout_i,
  output logic             div_clk_o,
  output logic             pin_o
);
  cfg_t cfg_q;
  logic tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  pow2_src_sel #(.N_SRC(N_SRC)) u_src (
    .tick_i (src_tick_i),
    .sel_i  (cfg_q.src),
    .gate_i (cfg_q.gate),
    .tick_o (tick)
  );

  pow2_div_core #(.CNT_W(CNT_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (cfg_q.run),
    .tap_i  (cfg_q.tap),
    .div_o  (div_clk_o)
  );

  pow2_pin_mux u_pin (
    .clk_mode_i (cfg_q.pin_clk),
    .div_i      (div_clk_o),
    .gpio_i     (gpio_dout_i),
    .pin_o      (pin_o)
  );
endmodule

// File: tb/pow2_clk_out_tb_top.sv
module pow2_clk_out_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] src_tick_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [8:0] cfg_wdata_i = '0;
  logic       gpio_dout_i = 1'b0;
  logic       div_clk_o, pin_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  int m_cnt = 0, m_tap_act = 0, m_tap = 0, m_src = 0;
  bit m_run = 0, m_en_d = 0, m_en = 0, m_gate = 0, m_mode = 0;

  pow2_clk_out dut_i (.*);

  always #5 clk_i = ~clk_i;

  function automatic bit m_div();
    return m_run && (((m_cnt >> m_tap_act) & 1) == 1);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_tap_act = 0; m_tap = 0; m_src = 0;
      m_run = 0; m_en_d = 0; m_en = 0; m_gate = 0; m_mode = 0;
    end else begin
      bit tk;
      bit tb_bit;
      tk = m_gate && src_tick_i[m_src];
      tb_bit = ((m_cnt >> m_tap_act) & 1) == 1;
      if (m_en && !m_en_d) begin
        m_cnt = 0; m_run = 1; m_tap_act = m_tap;
      end else if (m_run) begin
        if (!m_en && !tb_bit) m_run = 0;
        else if (tk) m_cnt = (m_cnt + 1) % 65536;
      end
      m_en_d = m_en;
      if (cfg_we_i) begin
        m_tap = cfg_wdata_i[3:0]; m_en = cfg_wdata_i[4];
        m_src = cfg_wdata_i[6:5]; m_gate = cfg_wdata_i[7]; m_mode = cfg_wdata_i[8];
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // source strobes and watchdog
  always @(negedge clk_i) begin
    cyc++;
    src_tick_i[0] <= 1'b1;
    src_tick_i[1] <= (cyc % 2) == 0;
    src_tick_i[2] <= (cyc % 3) == 0;
    src_tick_i[3] <= (cyc % 5) == 0;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // cycle compare against the model (R2 R4 R8)
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      bit exp_div, exp_pin;
      exp_div = m_div();
      exp_pin = m_mode ? exp_div : gpio_dout_i;
      chk(div_clk_o == exp_div, "R2 model div_clk_o", div_clk_o, exp_div);
      chk(pin_o == exp_pin, "R8 model pin_o", pin_o, exp_pin);
    end
  end

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic wr(input int tap, input bit run, input int src, input bit gate, input bit mode);
    cfg_wdata_i = {mode, gate, 2'(src), run, 4'(tap)};
    cfg_we_i = 1'b1;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev;
    prev = div_clk_o;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      step();
      if (!prev && div_clk_o) begin ok = 1; return; end
      prev = div_clk_o;
    end
  endtask

  task automatic period(output int p);
    bit ok;
    wait_rise(ok);
    p = 0;
    if (!ok) return;
    wait_rise(ok);
    for (int i = 0; i < 4000 && !ok; i++) ;
    p = -1;
  endtask

  task automatic measure(input string what, input int exp);
    bit ok, prev;
    int n;
    wait_rise(ok);
    n = 0;
    prev = 1;
    if (ok) begin
      for (int i = 0; i < 4000; i++) begin
        step();
        n++;
        if (!prev && div_clk_o) break;
        prev = div_clk_o;
      end
    end
    chk(ok && n == exp, what, n, exp);
  endtask

  task automatic stop_and_restart(input int tap, input int src);
    wr(tap, 0, src, 1, 1);
    for (int i = 0; i < 4000 && div_clk_o; i++) step();
    repeat (3) step();
    wr(tap, 1, src, 1, 1);
  endtask

  initial begin
    bit ok;
    int hi;
    bit ref_lvl;
    repeat (3) step();
    chk(div_clk_o == 0, "R1 reset div_clk_o", div_clk_o, 0);
    rst_ni = 1'b1;
    gpio_dout_i = 1'b1;
    step();
    chk(pin_o == 1, "R1 reset pin follows gpio", pin_o, 1);

    // R8 gpio mode while divider runs
    wr(0, 1, 0, 1, 0);
    gpio_dout_i = 1'b0; step();
    chk(pin_o == 0, "R8 gpio 0 on pin", pin_o, 0);
    gpio_dout_i = 1'b1; step();
    chk(pin_o == 1, "R8 gpio 1 on pin", pin_o, 1);

    // R2 periods, R9 field layout
    stop_and_restart(0, 0); measure("R2 period N=0", 2);
    stop_and_restart(1, 0); measure("R2 period N=1", 4);
    stop_and_restart(3, 0); measure("R2 period N=3", 16);
    stop_and_restart(7, 0); measure("R9 R2 period N=7", 256);

    // R3 first high edge 2^N cycles after restart clear
    wr(2, 0, 0, 1, 1);
    for (int i = 0; i < 4000 && div_clk_o; i++) step();
    repeat (3) step();
    wr(2, 1, 0, 1, 1); // rise seen at next edge, clear, then count
    hi = 0;
    for (int i = 0; i < 100 && !div_clk_o; i++) begin step(); hi++; end
    chk(hi == 5, "R3 cycles to first high after restart", hi, 5);

    // R4 disable mid-pulse: full high time, then stays low
    stop_and_restart(4, 0);
    wait_rise(ok);
    hi = 1;
    repeat (3) begin step(); hi++; end
    wr(4, 0, 0, 1, 1); hi++;
    for (int i = 0; i < 100 && div_clk_o; i++) begin step(); hi++; end
    chk(hi == 17, "R4 high samples incl falling one", hi, 17);
    ok = 1;
    repeat (40) begin step(); if (div_clk_o) ok = 0; end
    chk(ok, "R4 low after disable", div_clk_o, 0);

    // R5 tap change while stopped
    wr(2, 0, 0, 1, 1);
    ok = 1;
    repeat (20) begin step(); if (div_clk_o) ok = 0; end
    chk(ok, "R5 frozen low while stopped", div_clk_o, 0);
    wr(2, 1, 0, 1, 1);
    measure("R5 new tap after restart", 8);

    // R6 sources
    stop_and_restart(0, 1); measure("R6 src 1 period", 4);
    stop_and_restart(1, 2); measure("R6 src 2 period", 12);
    stop_and_restart(0, 3); measure("R6 src 3 period", 10);

    // R7 gate off freezes level
    stop_and_restart(3, 0);
    repeat (11) step();
    wr(3, 1, 0, 0, 1);
    step();
    ref_lvl = div_clk_o;
    ok = 1;
    repeat (40) begin step(); if (div_clk_o != ref_lvl) ok = 0; end
    chk(ok, "R7 gated divider holds", div_clk_o, ref_lvl);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule